// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Unit

This block holds the interrupt and accounting registers of a single-channel DMA engine. The data mover and descriptor logic report conditions as one-cycle pulses: transfer finished, descriptor finished, bus errors on data or descriptor reads, and completions on the source and destination sides. The block stores each condition in a sticky status register and combines the stored status with a mask to drive one level interrupt line.

Software reaches the block through a simple 32-bit register port with an address, separate read and write strobes, write data and registered read data. The mask register cannot be written directly. It changes only through two strobe registers, one that unmasks sources and one that masks them. A running byte total accumulates the sizes reported by the data mover and flags its own wraparound. Two completion counters clear themselves when software reads them, and they raise their own error bits if they saturate.

Register decode uses an enumerated register-select type: `SEL_STAT`, `SEL_MASK`, `SEL_ENA`, `SEL_DIS`, `SEL_BYTES`, `SEL_SRCCNT`, `SEL_DSTCNT`, and `SEL_NONE` for any unmapped offset. There are no sequential states. Every access completes in the cycle it is strobed, and read data appears on the next cycle.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the mask (0x104) reads 0x7FF, and the status (0x100), byte total (0x188), source count (0x190) and destination count (0x194) all read zero. `irq` and `reg_rdata` are low.
- R2: Each input pulse sets its sticky status bit one cycle later, and the bit stays set until it is cleared. The bit positions are: done 10, write-data error 9, read-data error 8, destination descriptor error 7, source descriptor error 6, destination descriptor done 2. Bits 1 and 31:11 always read zero.
- R3: A write to 0x100 clears exactly the status bits that are 1 in the write data. A write of zero changes nothing.
- R4: If an event pulse and a status clear of the same bit occur in the same cycle, the bit stays set.
- R5: Writing 1s to 0x108 clears the matching mask bits, and writing 1s to 0x10C sets them. Zero bits have no effect. Writing 0x104 directly changes nothing.
- R6: `irq` is registered. It is high in the cycle after any status bit with a zero mask bit is set, and low in the cycle after no such bit remains.
- R7: A write to 0x188 loads the byte total with the write data, so writing zero clears it. A `byte_add_valid` cycle adds `byte_add` to the total. If a write and an add occur in the same cycle, the write wins.
- R8: An add that carries out of the byte total keeps the wrapped low bits and sets status bit 3.
- R9: Pulses on `src_cmpl` and `dst_cmpl` increment the counters at 0x190 and 0x194. A read returns the count and clears it. A pulse in the same cycle as that read leaves the counter at 1.
- R10: A completion counter at 2^CNT_W-1 that receives another pulse stays at that value and sets status bit 4 (source) or bit 5 (destination).
- R11: A read or write to an unmapped offset sets status bit 0, and such a read returns zero. Reads of 0x108 and 0x10C return zero and do not set bit 0.
- R12: `reg_rdata` changes only on the cycle after a `reg_rd` strobe, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| evt_done | input | 1 | Transfer finished pulse |
| evt_wr_err | input | 1 | Write-data bus error pulse |
| evt_rd_err | input | 1 | Read-data bus error pulse |
| evt_dst_dscr_err | input | 1 | Destination descriptor read error pulse |
| evt_src_dscr_err | input | 1 | Source descriptor read error pulse |
| evt_dst_dscr_done | input | 1 | Destination descriptor finished pulse |
| byte_add_valid | input | 1 | Byte total add strobe |
| byte_add | input | BYTE_ADD_W | Bytes to add |
| src_cmpl | input | 1 | Source completion pulse |
| dst_cmpl | input | 1 | Destination completion pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the collisions in this block. An event that arrives in the same cycle as its clear is one; a design that lets the clear win would silently lose a done interrupt. A completion pulse that coincides with a clearing read is another; if that pulse is dropped, the destination count no longer matches the descriptors finished. The counter is driven one step past its maximum, where a wrapping design would read back zero and raise no error bit. The byte total is carried out of its top bit, where a missing carry check leaves bit 3 clear. The bench also checks the cycle in which `irq` rises and falls as the mask changes, and it checks that unmapped and write-only offsets leave the mask untouched and read back zero.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int STAT_W = 11;

    localparam int B_INVALID      = 0;
    localparam int B_DST_DONE     = 2;
    localparam int B_BYTE_OVF     = 3;
    localparam int B_SRC_CNTERR   = 4;
    localparam int B_DST_CNTERR   = 5;
    localparam int B_SRC_DSCR_ERR = 6;
    localparam int B_DST_DSCR_ERR = 7;
    localparam int B_RD_ERR       = 8;
    localparam int B_WR_ERR       = 9;
    localparam int B_DONE         = 10;

    localparam logic [11:0] OFS_STAT   = 12'h100;
    localparam logic [11:0] OFS_MASK   = 12'h104;
    localparam logic [11:0] OFS_ENA    = 12'h108;
    localparam logic [11:0] OFS_DIS    = 12'h10C;
    localparam logic [11:0] OFS_BYTES  = 12'h188;
    localparam logic [11:0] OFS_SRCCNT = 12'h190;
    localparam logic [11:0] OFS_DSTCNT = 12'h194;

    localparam int NUM_CMPL = 2;
    localparam int CMPL_SRC = 0;
    localparam int CMPL_DST = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK,
        SEL_ENA,
        SEL_DIS,
        SEL_BYTES,
        SEL_SRCCNT,
        SEL_DSTCNT
    } reg_sel_e;

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              bad_access
);

    always_comb begin
        unique case (addr)
            ADDR_W'(OFS_STAT):   sel = SEL_STAT;
            ADDR_W'(OFS_MASK):   sel = SEL_MASK;
            ADDR_W'(OFS_ENA):    sel = SEL_ENA;
            ADDR_W'(OFS_DIS):    sel = SEL_DIS;
            ADDR_W'(OFS_BYTES):  sel = SEL_BYTES;
            ADDR_W'(OFS_SRCCNT): sel = SEL_SRCCNT;
            ADDR_W'(OFS_DSTCNT): sel = SEL_DSTCNT;
            default:             sel = SEL_NONE;
        endcase
    end

    assign bad_access = (rd || wr) && (sel == SEL_NONE);

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] hw_set,
    input  logic [STAT_W-1:0] sw_clr,
    input  logic              ena_we,
    input  logic              dis_we,
    input  logic [STAT_W-1:0] bits,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq
);

    localparam logic [STAT_W-1:0] MASK_RST = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~sw_clr) | hw_set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else if (dis_we) begin
            mask_q <= mask_q | bits;
        end else if (ena_we) begin
            mask_q <= mask_q & ~bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |(stat_q & ~mask_q);
        end
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_q) & ~$past(sw_clr)) & ~stat_q) == '0)); // R2

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set & sw_clr) != '0) |=> ((stat_q & $past(hw_set & sw_clr)) == $past(hw_set & sw_clr))); // R4

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_we && !dis_we) |=> ((mask_q & $past(bits)) == '0)); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena_we && !dis_we) |=> $stable(mask_q)); // R5

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == ($past(stat_q & ~mask_q) != '0))); // R6

endmodule

// File: rtl/dma_cmpl_counter.sv
module dma_cmpl_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             sat_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic full;
    assign full    = (cnt_q == CNT_MAX);
    assign sat_evt = inc && full && !rd_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rd_clr) begin
            cnt_q <= inc ? CNT_W'(1) : '0;
        end else if (inc && !full) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && inc && !rd_clr) |=> (cnt_q == CNT_MAX)); // R10

    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !inc) |=> (cnt_q == '0)); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !rd_clr && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R9

endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
    parameter int BYTE_W     = 32,
    parameter int BYTE_ADD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [BYTE_W-1:0]     load_val,
    input  logic                  add_v,
    input  logic [BYTE_ADD_W-1:0] add,
    output logic [BYTE_W-1:0]     cnt_q,
    output logic                  ovf
);

    logic [BYTE_W:0] sum;
    assign sum = {1'b0, cnt_q} + {1'b0, BYTE_W'(add)};
    assign ovf = add_v && !load && sum[BYTE_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (add_v) begin
            cnt_q <= sum[BYTE_W-1:0];
        end
    end

    AST_BYTE_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        (add_v && !load) |=> (cnt_q == BYTE_W'($past(cnt_q) + BYTE_W'($past(add))))); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))); // R7

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int BYTE_W     = 32,
    parameter int BYTE_ADD_W = 16,
    parameter int CNT_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  evt_done,
    input  logic                  evt_wr_err,
    input  logic                  evt_rd_err,
    input  logic                  evt_dst_dscr_err,
    input  logic                  evt_src_dscr_err,
    input  logic                  evt_dst_dscr_done,
    input  logic                  byte_add_valid,
    input  logic [BYTE_ADD_W-1:0] byte_add,
    input  logic                  src_cmpl,
    input  logic                  dst_cmpl,
    output logic                  irq
);

    reg_sel_e          sel;
    logic              bad_access;
    logic [STAT_W-1:0] hw_set;
    logic [STAT_W-1:0] sw_clr;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] mask_q;
    logic [BYTE_W-1:0] byte_cnt;
    logic              byte_ovf;
    logic [DATA_W-1:0] rd_mux;

    logic [NUM_CMPL-1:0] cmpl_inc;
    logic [NUM_CMPL-1:0] cmpl_rd;
    logic [NUM_CMPL-1:0] cmpl_sat;
    logic [CNT_W-1:0]    cmpl_cnt [NUM_CMPL];

    dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr       (reg_addr),
        .rd         (reg_rd),
        .wr         (reg_wr),
        .sel        (sel),
        .bad_access (bad_access)
    );

    assign sw_clr = (reg_wr && sel == SEL_STAT) ? reg_wdata[STAT_W-1:0] : '0;

    always_comb begin
        hw_set                 = '0;
        hw_set[B_INVALID]      = bad_access;
        hw_set[B_DST_DONE]     = evt_dst_dscr_done;
        hw_set[B_BYTE_OVF]     = byte_ovf;
        hw_set[B_SRC_CNTERR]   = cmpl_sat[CMPL_SRC];
        hw_set[B_DST_CNTERR]   = cmpl_sat[CMPL_DST];
        hw_set[B_SRC_DSCR_ERR] = evt_src_dscr_err;
        hw_set[B_DST_DSCR_ERR] = evt_dst_dscr_err;
        hw_set[B_RD_ERR]       = evt_rd_err;
        hw_set[B_WR_ERR]       = evt_wr_err;
        hw_set[B_DONE]         = evt_done;
    end

    dma_irq_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_clr (sw_clr),
        .ena_we (reg_wr && sel == SEL_ENA),
        .dis_we (reg_wr && sel == SEL_DIS),
        .bits   (reg_wdata[STAT_W-1:0]),
        .stat_q (stat_q),
        .mask_q (mask_q),
        .irq    (irq)
    );

    dma_byte_counter #(
        .BYTE_W     (BYTE_W),
        .BYTE_ADD_W (BYTE_ADD_W)
    ) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_wr && sel == SEL_BYTES),
        .load_val (reg_wdata[BYTE_W-1:0]),
        .add_v    (byte_add_valid),
        .add      (byte_add),
        .cnt_q    (byte_cnt),
        .ovf      (byte_ovf)
    );

    assign cmpl_inc[CMPL_SRC] = src_cmpl;
    assign cmpl_inc[CMPL_DST] = dst_cmpl;
    assign cmpl_rd[CMPL_SRC]  = reg_rd && sel == SEL_SRCCNT;
    assign cmpl_rd[CMPL_DST]  = reg_rd && sel == SEL_DSTCNT;

    for (genvar g = 0; g < NUM_CMPL; g++) begin : g_cmpl
        dma_cmpl_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (cmpl_inc[g]),
            .rd_clr  (cmpl_rd[g]),
            .cnt_q   (cmpl_cnt[g]),
            .sat_evt (cmpl_sat[g])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_STAT:   rd_mux = DATA_W'(stat_q & ~(STAT_W'(1) << 1));
            SEL_MASK:   rd_mux = DATA_W'(mask_q);
            SEL_BYTES:  rd_mux = DATA_W'(byte_cnt);
            SEL_SRCCNT: rd_mux = DATA_W'(cmpl_cnt[CMPL_SRC]);
            SEL_DSTCNT: rd_mux = DATA_W'(cmpl_cnt[CMPL_DST]);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && bad_access) |=> (reg_rdata == '0)); // R11

    AST_UNMAPPED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> stat_q[B_INVALID]); // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R12

    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ovf |=> stat_q[B_BYTE_OVF]); // R8

endmodule

// File: tb/dma_irq_unit_test.sv
module dma_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] reg_addr;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        evt_done, evt_wr_err, evt_rd_err;
    logic        evt_dst_dscr_err, evt_src_dscr_err, evt_dst_dscr_done;
    logic        byte_add_valid;
    logic [15:0] byte_add;
    logic        src_cmpl, dst_cmpl;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    dma_irq_unit uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_addr         (reg_addr),
        .reg_wr           (reg_wr),
        .reg_rd           (reg_rd),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .evt_done         (evt_done),
        .evt_wr_err       (evt_wr_err),
        .evt_rd_err       (evt_rd_err),
        .evt_dst_dscr_err (evt_dst_dscr_err),
        .evt_src_dscr_err (evt_src_dscr_err),
        .evt_dst_dscr_done(evt_dst_dscr_done),
        .byte_add_valid   (byte_add_valid),
        .byte_add         (byte_add),
        .src_cmpl         (src_cmpl),
        .dst_cmpl         (dst_cmpl),
        .irq              (irq)
    );

    // op: 0 write, 1 read and compare, 2 event pulse (data holds status bit positions)
    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NVEC = 28;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 4'd1,  12'h104, 32'h0000_07FF}, // R1 mask reset
        '{2'd1, 4'd1,  12'h100, 32'h0000_0000}, // R1 status reset
        '{2'd1, 4'd1,  12'h188, 32'h0000_0000}, // R1 byte total reset
        '{2'd1, 4'd1,  12'h190, 32'h0000_0000}, // R1 source count reset
        '{2'd2, 4'd2,  12'h000, 32'h0000_0404}, // R2 done + dst descriptor done
        '{2'd1, 4'd2,  12'h100, 32'h0000_0404}, // R2
        '{2'd0, 4'd3,  12'h100, 32'h0000_0004}, // R3 clear bit 2
        '{2'd1, 4'd3,  12'h100, 32'h0000_0400}, // R3
        '{2'd0, 4'd3,  12'h100, 32'h0000_0000}, // R3 zero write
        '{2'd1, 4'd3,  12'h100, 32'h0000_0400}, // R3
        '{2'd0, 4'd5,  12'h108, 32'h0000_0400}, // R5 unmask bit 10
        '{2'd1, 4'd5,  12'h104, 32'h0000_03FF}, // R5
        '{2'd0, 4'd5,  12'h104, 32'h0000_0000}, // R5 direct mask write ignored
        '{2'd1, 4'd5,  12'h104, 32'h0000_03FF}, // R5
        '{2'd0, 4'd5,  12'h10C, 32'h0000_0400}, // R5 mask bit 10
        '{2'd1, 4'd5,  12'h104, 32'h0000_07FF}, // R5
        '{2'd0, 4'd3,  12'h100, 32'h0000_0400}, // R3
        '{2'd2, 4'd2,  12'h000, 32'h0000_03C0}, // R2 error pulses bits 9..6
        '{2'd1, 4'd2,  12'h100, 32'h0000_03C0}, // R2
        '{2'd0, 4'd3,  12'h100, 32'h0000_07FF}, // R3
        '{2'd1, 4'd11, 12'h108, 32'h0000_0000}, // R11 write-only reads zero
        '{2'd1, 4'd11, 12'h100, 32'h0000_0000}, // R11 no invalid flag
        '{2'd1, 4'd11, 12'h0F0, 32'h0000_0000}, // R11 unmapped read
        '{2'd1, 4'd11, 12'h100, 32'h0000_0001}, // R11 invalid flag set
        '{2'd0, 4'd11, 12'h100, 32'h0000_0001}, // R11 clear it
        '{2'd0, 4'd11, 12'h200, 32'h0000_0005}, // R11 unmapped write
        '{2'd1, 4'd11, 12'h100, 32'h0000_0001}, // R11
        '{2'd0, 4'd3,  12'h100, 32'h0000_0001}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic drive_events(input logic [31:0] b);
        evt_done          = b[10];
        evt_wr_err        = b[9];
        evt_rd_err        = b[8];
        evt_dst_dscr_err  = b[7];
        evt_src_dscr_err  = b[6];
        evt_dst_dscr_done = b[2];
    endtask

    task automatic pulse_events(input logic [31:0] b);
        @(negedge clk);
        drive_events(b);
        @(negedge clk);
        drive_events(32'h0);
    endtask

    task automatic add_bytes(input logic [15:0] v);
        @(negedge clk);
        byte_add_valid = 1'b1; byte_add = v;
        @(negedge clk);
        byte_add_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        drive_events(32'h0);
        byte_add_valid = 1'b0; byte_add = '0;
        src_cmpl = 1'b0; dst_cmpl = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rdata", reg_rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            unique case (VECS[i].op)
                2'd0: reg_write(VECS[i].addr, VECS[i].data);
                2'd2: pulse_events(VECS[i].data);
                default: begin
                    reg_read(VECS[i].addr, rv);
                    check($sformatf("R%0d vec %0d", VECS[i].req, i), rv, VECS[i].data);
                end
            endcase
        end

        // R12: read data holds while no read strobe
        reg_read(12'h104, rv);
        repeat (3) @(negedge clk);
        check("R12 hold", reg_rdata, 32'h7FF);

        // R6: irq timing against status and mask
        reg_write(12'h108, 32'h400);
        @(negedge clk); evt_done = 1'b1;
        @(negedge clk); evt_done = 1'b0;
        check("R6 registered delay", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R6 rise", {31'b0, irq}, 32'h1);
        reg_write(12'h10C, 32'h400);
        check("R6 masked one cycle late", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R6 masked", {31'b0, irq}, 32'h0);
        reg_write(12'h108, 32'h400);
        @(negedge clk);
        check("R6 unmasked again", {31'b0, irq}, 32'h1);
        reg_write(12'h100, 32'h400);
        @(negedge clk);
        check("R6 cleared", {31'b0, irq}, 32'h0);
        reg_write(12'h10C, 32'h7FF);

        // R4: event and clear of same bit in same cycle
        @(negedge clk);
        reg_addr = 12'h100; reg_wdata = 32'h400; reg_wr = 1'b1; evt_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_done = 1'b0;
        reg_read(12'h100, rv);
        check("R4 event wins", rv, 32'h400);
        reg_write(12'h100, 32'h7FF);

        // R7 / R8: byte total
        add_bytes(16'h0100); add_bytes(16'h0100); add_bytes(16'h0100);
        reg_read(12'h188, rv);
        check("R7 accumulate", rv, 32'h300);
        reg_write(12'h188, 32'h0);
        reg_read(12'h188, rv);
        check("R7 clear by zero write", rv, 32'h0);
        reg_write(12'h188, 32'hFFFF_FFF0);
        add_bytes(16'h0020);
        reg_read(12'h188, rv);
        check("R8 wrapped total", rv, 32'h10);
        reg_read(12'h100, rv);
        check("R8 overflow bit", rv, 32'h008);
        reg_write(12'h100, 32'h7FF);
        @(negedge clk);
        reg_addr = 12'h188; reg_wdata = 32'h50; reg_wr = 1'b1;
        byte_add_valid = 1'b1; byte_add = 16'h0007;
        @(negedge clk);
        reg_wr = 1'b0; byte_add_valid = 1'b0;
        reg_read(12'h188, rv);
        check("R7 write wins", rv, 32'h50);

        // R9: completion counters clear on read
        repeat (5) begin
            @(negedge clk); src_cmpl = 1'b1;
            @(negedge clk); src_cmpl = 1'b0;
        end
        reg_read(12'h190, rv);
        check("R9 src count", rv, 32'd5);
        reg_read(12'h190, rv);
        check("R9 src cleared", rv, 32'd0);
        repeat (3) begin
            @(negedge clk); dst_cmpl = 1'b1;
            @(negedge clk); dst_cmpl = 1'b0;
        end
        @(negedge clk);
        reg_addr = 12'h194; reg_rd = 1'b1; dst_cmpl = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; dst_cmpl = 1'b0;
        check("R9 dst read value", reg_rdata, 32'd3);
        reg_read(12'h194, rv);
        check("R9 pulse during read kept", rv, 32'd1);

        // R10: saturation
        @(negedge clk); src_cmpl = 1'b1;
        repeat (255) @(negedge clk);
        src_cmpl = 1'b0;
        reg_read(12'h100, rv);
        check("R10 no error at max", rv, 32'h0);
        reg_read(12'h190, rv);
        check("R10 reach max", rv, 32'd255);
        @(negedge clk); src_cmpl = 1'b1; dst_cmpl = 1'b1;
        repeat (256) @(negedge clk);
        src_cmpl = 1'b0; dst_cmpl = 1'b0;
        reg_read(12'h100, rv);
        check("R10 count error bits", rv, 32'h030);
        reg_read(12'h190, rv);
        check("R10 src saturated", rv, 32'd255);
        reg_read(12'h194, rv);
        check("R10 dst saturated", rv, 32'd255);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule